// File: doc/BRIEF.md
# Receiver Polling Duty-Cycle Sequencer

This block duty-cycles an external radio receiver so that the receiver is only powered for short, periodic listening windows. It drives two control lines, a chip enable and a receive-on line. It steps through a fixed ring of phases: an idle standby interval, a two-stage start-up, a validation gate in which an external preburst checker is launched, and, on success, a data-reception phase. A failed validation sends the sequencer straight back to standby. A data-complete strobe ends reception and also returns it to standby.

All waits are measured in ticks of an external timebase strobe (`tick_i`), not in clock cycles. The start-up consists of two back-to-back waits: first a synthesizer settling interval, then a signal-chain settling interval. Each is chosen per data-rate range by a two-bit rate selector, so that slower rates can be given longer settling. The standby length and the eight per-rate settling counts sit in tick-count registers loaded through a small write port. For reliable capture, the transmitter's preburst has to last at least as long as one standby interval, the full start-up and the validation window added together. Software picks the register values with that budget in mind.

There is no streaming data path. Every pin is a plain level or single-cycle strobe with no back-pressure.

Top module: `rxpoll_sequencer`

## Requirements
- R1: While `rst` is high (sampled synchronously), `phase_o` reads 0 (standby), `rx_receive_o` is low, `chk_start_o` is low and `rx_enable_o` is low.
- R2: From the first clock edge after reset, `rx_enable_o` is high in every phase. `rx_receive_o` is low exactly when the phase is standby and high in start-up, validation and reception.
- R3: Phase codes on `phase_o` are 0 standby, 1 synthesizer wait, 2 signal-chain wait, 3 validation, 4 reception. Standby lasts exactly S ticks and then moves to code 1, where S is the standby register; S = 0 behaves as 1. Clock cycles without a tick never move a timed phase (codes 0 to 2).
- R4: The rate selector is sampled on the edge that leaves standby. The synthesizer wait lasts P ticks, where P is the synthesizer register of that rate (0 behaves as 1), and then moves to code 2.
- R5: The signal-chain wait lasts G ticks, where G is the signal-chain register of the same sampled rate (0 behaves as 1), and then moves to code 3. Changing `rate_sel_i` after standby has been left has no effect until the next start-up.
- R6: `chk_start_o` is high for exactly one cycle, the first cycle in which the phase reads 3.
- R7: In validation, `chk_fail_i` returns the phase to standby on the next edge. If `chk_pass_i` arrives in the same cycle, the fail wins.
- R8: In validation, `chk_pass_i` without `chk_fail_i` moves the phase to reception on the next edge.
- R9: In reception, `data_done_i` returns the phase to standby on the next edge. Ticks, pass and fail strobes leave reception unchanged.
- R10: Pass, fail and done strobes have no effect outside the phase that consumes them. Ticks have no effect in validation.
- R11: A write with `cfg_wr_i` high stores `cfg_data_i` by `cfg_addr_i`: address 0 is the standby count, 4+r is the synthesizer count of rate r, 8+r is the signal-chain count of rate r. All other addresses are ignored. After reset the counts are 4 (standby), 3 (every synthesizer count) and 2 (every signal-chain count). The running phase compares against the live register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase strobe, one cycle per tick |
| rate_sel_i | input | RATE_W (2) | Data-rate range selector |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | RATE_W+2 (4) | Register write address |
| cfg_data_i | input | CNT_W (16) | Register write data, in ticks |
| chk_pass_i | input | 1 | Validation passed strobe |
| chk_fail_i | input | 1 | Validation failed strobe |
| data_done_i | input | 1 | Data reception complete strobe |
| rx_enable_o | output | 1 | Receiver chip enable |
| rx_receive_o | output | 1 | Receiver active (receive-on) line |
| chk_start_o | output | 1 | One-cycle launch of the preburst checker |
| phase_o | output | 3 | Current phase code |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. A tick held for one cycle moves an expiring timed phase on that edge. A consumed strobe moves validation or reception on that edge. `chk_start_o` rises on the same edge that makes the phase read 3. The bench therefore drives each stimulus for a single cycle starting at a falling edge. It samples the outputs at the next falling edge, and between ticks it adds strobe-only cycles to confirm that nothing moves. Phase lengths are checked by counting ticks one at a time against the expected S, P and G for every rate. A rate change is applied mid-start-up, and decoy values are written into the neighbouring rate's registers.

// File: rtl/rxpoll_pkg.sv
package rxpoll_pkg;

  typedef enum logic [2:0] {
    PH_STBY  = 3'd0,
    PH_PLL   = 3'd1,
    PH_SIG   = 3'd2,
    PH_CHECK = 3'd3,
    PH_RECV  = 3'd4
  } phase_e;

  // upper two address bits select the register group
  localparam logic [1:0] GRP_STBY = 2'd0;
  localparam logic [1:0] GRP_PLL  = 2'd1;
  localparam logic [1:0] GRP_SIG  = 2'd2;

endpackage

// File: rtl/rxpoll_cfg_regs.sv
module rxpoll_cfg_regs
  import rxpoll_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned RATE_W   = 2,
  parameter int unsigned STBY_RST = 4,
  parameter int unsigned PLL_RST  = 3,
  parameter int unsigned SIG_RST  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [RATE_W+1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  phase_e            sel_phase,
  input  logic [RATE_W-1:0] sel_rate,
  output logic [CNT_W-1:0]  cur_lim
);

  localparam int unsigned NR = 1 << RATE_W;

  logic [1:0]        grp;
  logic [RATE_W-1:0] idx;
  logic [CNT_W-1:0]  stby_q;
  logic [NR-1:0][CNT_W-1:0] pll_vec;
  logic [NR-1:0][CNT_W-1:0] sig_vec;

  assign grp = wr_addr[RATE_W+1:RATE_W];
  assign idx = wr_addr[RATE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stby_q <= CNT_W'(STBY_RST);
    end else if (wr_en && grp == GRP_STBY && idx == '0) begin
      stby_q <= wr_data;
    end
  end

  for (genvar g = 0; g < NR; g++) begin : g_rate
    logic [CNT_W-1:0] pll_r;
    logic [CNT_W-1:0] sig_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        pll_r <= CNT_W'(PLL_RST);
        sig_r <= CNT_W'(SIG_RST);
      end else if (wr_en && idx == RATE_W'(g)) begin
        if (grp == GRP_PLL) pll_r <= wr_data;
        if (grp == GRP_SIG) sig_r <= wr_data;
      end
    end
    assign pll_vec[g] = pll_r;
    assign sig_vec[g] = sig_r;
  end

  always_comb begin
    case (sel_phase)
      PH_STBY: cur_lim = stby_q;
      PH_PLL:  cur_lim = pll_vec[sel_rate];
      PH_SIG:  cur_lim = sig_vec[sel_rate];
      default: cur_lim = '0;
    endcase
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(stby_q)); // R11

endmodule

// File: rtl/rxpoll_tick_timer.sv
module rxpoll_tick_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             timed,
  input  logic             clr,
  input  logic [CNT_W-1:0] lim,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  // a limit of zero expires on the first tick, same as one
  assign expire  = tick && timed && (cnt_nxt >= {1'b0, lim});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (tick && timed) begin
      cnt_q <= cnt_nxt[CNT_W-1:0];
    end
  end

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    cnt_q != '1); // R3

endmodule

// File: rtl/rxpoll_phase_fsm.sv
module rxpoll_phase_fsm
  import rxpoll_pkg::*;
#(
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              expire,
  input  logic              chk_pass,
  input  logic              chk_fail,
  input  logic              data_done,
  output phase_e            phase,
  output logic [RATE_W-1:0] rate_q,
  output logic              timed,
  output logic              clr,
  output logic              chk_start,
  output logic              en
);

  phase_e phase_q, phase_n;

  always_comb begin
    phase_n = phase_q;
    case (phase_q)
      PH_STBY:  if (expire) phase_n = PH_PLL;
      PH_PLL:   if (expire) phase_n = PH_SIG;
      PH_SIG:   if (expire) phase_n = PH_CHECK;
      PH_CHECK: begin
        if (chk_fail)      phase_n = PH_STBY;
        else if (chk_pass) phase_n = PH_RECV;
      end
      PH_RECV:  if (data_done) phase_n = PH_STBY;
      default:  phase_n = PH_STBY;
    endcase
  end

  assign timed = (phase_q == PH_STBY) || (phase_q == PH_PLL) || (phase_q == PH_SIG);
  assign clr   = (phase_n != phase_q);
  assign phase = phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_STBY;
      rate_q    <= '0;
      chk_start <= 1'b0;
      en        <= 1'b0;
    end else begin
      phase_q   <= phase_n;
      if (phase_q == PH_STBY && phase_n == PH_PLL) rate_q <= rate_sel;
      chk_start <= (phase_n == PH_CHECK) && (phase_q != PH_CHECK);
      en        <= 1'b1;
    end
  end

  AST_FAIL_EXIT: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CHECK && chk_fail) |=> phase_q == PH_STBY); // R7
  AST_PASS_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CHECK && chk_pass && !chk_fail) |=> phase_q == PH_RECV); // R8
  AST_DONE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RECV && data_done) |=> phase_q == PH_STBY); // R9
  AST_CHK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    chk_start |=> !chk_start); // R6
  AST_RATE_HELD: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_STBY) |=> $stable(rate_q)); // R5

endmodule

// File: rtl/rxpoll_sequencer.sv
module rxpoll_sequencer
  import rxpoll_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned RATE_W   = 2,
  parameter int unsigned STBY_RST = 4,
  parameter int unsigned PLL_RST  = 3,
  parameter int unsigned SIG_RST  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [RATE_W-1:0] rate_sel_i,
  input  logic              cfg_wr_i,
  input  logic [RATE_W+1:0] cfg_addr_i,
  input  logic [CNT_W-1:0]  cfg_data_i,
  input  logic              chk_pass_i,
  input  logic              chk_fail_i,
  input  logic              data_done_i,
  output logic              rx_enable_o,
  output logic              rx_receive_o,
  output logic              chk_start_o,
  output logic [2:0]        phase_o
);

  phase_e            phase;
  logic [RATE_W-1:0] rate_q;
  logic              timed, clr, expire, en;
  logic [CNT_W-1:0]  lim;

  rxpoll_cfg_regs #(
    .CNT_W(CNT_W), .RATE_W(RATE_W),
    .STBY_RST(STBY_RST), .PLL_RST(PLL_RST), .SIG_RST(SIG_RST)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr_i), .wr_addr(cfg_addr_i),
    .wr_data(cfg_data_i), .sel_phase(phase), .sel_rate(rate_q), .cur_lim(lim)
  );

  rxpoll_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .tick(tick_i), .timed(timed), .clr(clr),
    .lim(lim), .expire(expire)
  );

  rxpoll_phase_fsm #(.RATE_W(RATE_W)) u_fsm (
    .clk(clk), .rst(rst), .rate_sel(rate_sel_i), .expire(expire),
    .chk_pass(chk_pass_i), .chk_fail(chk_fail_i), .data_done(data_done_i),
    .phase(phase), .rate_q(rate_q), .timed(timed), .clr(clr),
    .chk_start(chk_start_o), .en(en)
  );

  assign phase_o      = phase;
  assign rx_enable_o  = en;
  assign rx_receive_o = (phase != PH_STBY);

  AST_TICK_GATES_WAITS: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && phase_o <= 3'd2) |=> $stable(phase_o)); // R3
  AST_ENABLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> rx_enable_o); // R2

endmodule

// File: tb/rxpoll_sequencer_test.sv
`timescale 1ns/1ps
module rxpoll_sequencer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic [1:0] rate_sel_i = 2'd0;
  logic       cfg_wr_i = 1'b0;
  logic [3:0] cfg_addr_i = 4'd0;
  logic [15:0] cfg_data_i = 16'd0;
  logic       chk_pass_i = 1'b0;
  logic       chk_fail_i = 1'b0;
  logic       data_done_i = 1'b0;
  logic       rx_enable_o, rx_receive_o, chk_start_o;
  logic [2:0] phase_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  rxpoll_sequencer uut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .rate_sel_i(rate_sel_i),
    .cfg_wr_i(cfg_wr_i), .cfg_addr_i(cfg_addr_i), .cfg_data_i(cfg_data_i),
    .chk_pass_i(chk_pass_i), .chk_fail_i(chk_fail_i), .data_done_i(data_done_i),
    .rx_enable_o(rx_enable_o), .rx_receive_o(rx_receive_o),
    .chk_start_o(chk_start_o), .phase_o(phase_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic tick_once();
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic pulse(input bit p, input bit f, input bit d);
    chk_pass_i = p; chk_fail_i = f; data_done_i = d;
    @(negedge clk);
    chk_pass_i = 1'b0; chk_fail_i = 1'b0; data_done_i = 1'b0;
  endtask

  task automatic wr(input int a, input int v);
    cfg_wr_i = 1'b1; cfg_addr_i = 4'(a); cfg_data_i = 16'(v);
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic run_cycle(input int r, input int s, input int p, input int g, input int outcome);
    int es, ep, eg;
    es = (s == 0) ? 1 : s;
    ep = (p == 0) ? 1 : p;
    eg = (g == 0) ? 1 : g;
    rate_sel_i = 2'(r);
    pulse(1, 1, 1);
    chk("R10 strobes in standby", int'(phase_o), 0);
    for (int i = 0; i < es; i++) begin
      chk("R3 standby length", int'(phase_o), 0);
      chk("R2 receive low in standby", int'(rx_receive_o), 0);
      chk("R2 enable high", int'(rx_enable_o), 1);
      @(negedge clk);
      chk("R3 no move without tick", int'(phase_o), 0);
      tick_once();
    end
    chk("R4 enter synth wait", int'(phase_o), 1);
    rate_sel_i = 2'((r + 1) % 4);
    for (int i = 0; i < ep; i++) begin
      chk("R4 synth wait length", int'(phase_o), 1);
      chk("R2 receive high in start-up", int'(rx_receive_o), 1);
      if (i == 0) begin
        pulse(1, 1, 1);
        chk("R10 strobes in synth wait", int'(phase_o), 1);
      end
      tick_once();
    end
    chk("R4 enter signal wait", int'(phase_o), 2);
    for (int i = 0; i < eg; i++) begin
      chk("R5 signal wait length", int'(phase_o), 2);
      tick_once();
    end
    chk("R5 enter validation", int'(phase_o), 3);
    chk("R6 launch pulse high", int'(chk_start_o), 1);
    @(negedge clk);
    chk("R6 launch pulse one cycle", int'(chk_start_o), 0);
    tick_once();
    tick_once();
    chk("R10 ticks in validation", int'(phase_o), 3);
    pulse(0, 0, 1);
    chk("R10 done in validation", int'(phase_o), 3);
    chk("R2 receive high in validation", int'(rx_receive_o), 1);
    if (outcome == 0) begin
      pulse(0, 1, 0);
      chk("R7 fail to standby", int'(phase_o), 0);
    end else if (outcome == 2) begin
      pulse(1, 1, 0);
      chk("R7 fail beats pass", int'(phase_o), 0);
    end else begin
      pulse(1, 0, 0);
      chk("R8 pass to reception", int'(phase_o), 4);
      tick_once();
      pulse(1, 1, 0);
      chk("R9 reception holds", int'(phase_o), 4);
      chk("R2 receive high in reception", int'(rx_receive_o), 1);
      pulse(0, 0, 1);
      chk("R9 done to standby", int'(phase_o), 0);
    end
    chk("R6 no launch outside entry", int'(chk_start_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset phase", int'(phase_o), 0);
    chk("R1 reset receive", int'(rx_receive_o), 0);
    chk("R1 reset launch", int'(chk_start_o), 0);
    chk("R1 reset enable", int'(rx_enable_o), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 enable after reset", int'(rx_enable_o), 1);
    chk("R1 standby after reset", int'(phase_o), 0);

    // R11 reset defaults 4/3/2
    run_cycle(0, 4, 3, 2, 1);
    // R11 unmapped addresses ignored
    for (int a = 1; a < 4; a++) wr(a, 1);
    for (int a = 12; a < 16; a++) wr(a, 1);
    run_cycle(1, 4, 3, 2, 0);

    for (int r = 0; r < 4; r++) begin
      int s, p, g;
      s = 1 + r;
      p = 2 + r;
      g = (r == 3) ? 0 : 3 - r;
      wr(4 + (r + 1) % 4, 7);
      wr(8 + (r + 1) % 4, 6);
      wr(0, s);
      wr(4 + r, p);
      wr(8 + r, g);
      run_cycle(r, s, p, g, r % 3);
    end

    // standby count of zero acts as one; rate 2 keeps p=4, g=1
    wr(0, 0);
    run_cycle(2, 0, 4, 1, 1);
    run_cycle(2, 0, 4, 1, 2);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule